// File: doc/BRIEF.md
# Quadrature Position Axis

One axis of an incremental-encoder position counter. The two quadrature channels and the index input are brought into the clock domain through synchronising flops. Every edge on either channel then moves a 24-bit up/down count by one, so the count is four times the line count of the encoder. The count is signed two's complement and wraps at 2^24 without saturating.

Software never reads the live counter. It reads a 24-bit holding register that takes a snapshot of the count on a chosen event. That event is either the rising edge of the index input, or a latch-request strobe shared with other axes and driven by a timer or by software. An index capture also sets a sticky sense flag, which a read strobe clears. The count can be forced to a 24-bit value while a level-held load control is high. It can also be preset to a second value whenever the index rises.

Top module: `qpa_axis`

## Requirements
- R1: After reset the count, the holding register `hold_q` and the sense flag `sense_q` are all zero.
- R2: With the channels taken as the 2-bit code {A,B}, each step along 00→01→11→10→00 adds one to the count and each step the other way subtracts one. Every single-channel edge counts.
- R3: A sample in which A and B both change leaves the count unchanged.
- R4: The count wraps modulo 2^24. A step down from 0 gives 0xFFFFFF (−1), and a step up from 0xFFFFFF gives 0.
- R5: With `sel_index` = 0, `hold_q` takes the count present at a clock edge where `latch_req` is high. Otherwise it keeps its value, and an index rise does not change it.
- R6: With `sel_index` = 1, `hold_q` takes the count only on a rising edge of the synchronised index, and `latch_req` has no effect.
- R7: An index rise while `sel_index` = 1 sets `sense_q`. It stays set until a cycle with `sense_rd` high clears it, and a set in the same cycle wins over the clear. With `sel_index` = 0 an index rise does not set it.
- R8: While `load_hold` is high the count is loaded with `load_val` every cycle. The load wins over an index preset and over a count edge.
- R9: With `preset_en` = 1, each synchronised index rise loads the count with `preset_val`. This wins over a count edge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Quadrature channel A, asynchronous |
| enc_b | input | 1 | Quadrature channel B, asynchronous |
| enc_idx | input | 1 | Index pulse, asynchronous |
| latch_req | input | 1 | Shared snapshot request, one cycle |
| sel_index | input | 1 | 1: snapshot on index rise; 0: on latch_req |
| preset_en | input | 1 | Load preset_val on index rise |
| load_hold | input | 1 | Level-held load of load_val |
| load_val | input | 24 | Value loaded while load_hold is high |
| preset_val | input | 24 | Value loaded on index rise |
| sense_rd | input | 1 | Read strobe that clears sense_q |
| hold_q | output | 24 | Snapshot of the count, two's complement |
| sense_q | output | 1 | Sticky index-sense flag |

## Verification
The walk through the code table reverses direction and crosses zero, so a decoder with the direction swapped or a counter that saturates gives wrong snapshots. A step in which both channels change checks that a bad transition is dropped rather than counted twice or once. The bench makes a channel edge reach the counter in the same cycle as a load or an index preset. A design with the priority wrong ends one count away from the forced value. The bench also strobes `latch_req` while the index source is selected, and raises the index while the request source is selected. A design that mixes up the two sources shows a changed `hold_q` or a stray `sense_q`.

// File: rtl/qpa_pkg.sv
package qpa_pkg;
  localparam int unsigned CNT_W_DEF = 24;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;
endpackage

// File: rtl/qpa_sync.sv
module qpa_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (gi == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_rest
        assign stage_d = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= '0;
        else        stage_q[gi] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/qpa_decode.sv
module qpa_decode
  import qpa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a_s,
  input  logic  b_s,
  input  logic  idx_s,
  output step_e step_o,
  output logic  idx_rise_o
);
  logic a_prev_q, b_prev_q, idx_prev_q;
  step_e step_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev_q   <= 1'b0;
      b_prev_q   <= 1'b0;
      idx_prev_q <= 1'b0;
    end else begin
      a_prev_q   <= a_s;
      b_prev_q   <= b_s;
      idx_prev_q <= idx_s;
    end
  end

  always_comb begin
    logic ch_a, ch_b;
    ch_a = a_s ^ a_prev_q;
    ch_b = b_s ^ b_prev_q;
    step_d = STEP_NONE;
    if (ch_a && ch_b)    step_d = STEP_BAD;
    else if (ch_a || ch_b) begin
      // forward order 00->01->11->10: new A equals old B
      if (a_s == b_prev_q) step_d = STEP_UP;
      else                 step_d = STEP_DN;
    end
  end

  assign step_o     = step_d;
  assign idx_rise_o = idx_s & ~idx_prev_q;

  // R3: a step that changes both channels is never reported as motion
  p_bad_not_counted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_s != a_prev_q) && (b_s != b_prev_q)) |-> (step_o == STEP_BAD));
  // R2: a direction is reported only when exactly one channel moved
  p_single_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o == STEP_UP || step_o == STEP_DN) |-> $countones({a_s ^ a_prev_q, b_s ^ b_prev_q}) == 1);
endmodule

// File: rtl/qpa_counter.sv
module qpa_counter
  import qpa_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step_i,
  input  logic             idx_rise_i,
  input  logic             preset_en,
  input  logic             load_hold,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] preset_val,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;
  logic             preset_hit;

  assign preset_hit = preset_en & idx_rise_i;

  always_comb begin
    count_en = 1'b1;
    count_d  = count_q;
    if (load_hold)                count_d = load_val;
    else if (preset_hit)          count_d = preset_val;
    else if (step_i == STEP_UP)   count_d = count_q + ONE;
    else if (step_i == STEP_DN)   count_d = count_q - ONE;
    else                          count_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count_o = count_q;

  // R8: level-held load forces the count regardless of other events
  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_hold |=> (count_q == $past(load_val)));
  // R9: index preset beats a count edge
  p_preset_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_hold && preset_en && idx_rise_i) |=> (count_q == $past(preset_val)));
  // R4: an up step is modulo 2^CNT_W
  p_up_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_hold && !preset_hit && step_i == STEP_UP) |=> (count_q == $past(count_q) + ONE));
  // R3: with no event the count holds
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_hold && !preset_hit && (step_i == STEP_NONE || step_i == STEP_BAD)) |=> $stable(count_q));
endmodule

// File: rtl/qpa_snap.sv
module qpa_snap #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             idx_rise_i,
  input  logic             latch_req,
  input  logic             sel_index,
  input  logic             sense_rd,
  output logic [CNT_W-1:0] hold_o,
  output logic             sense_o
);
  logic [CNT_W-1:0] hold_q;
  logic             sense_q, sense_d;
  logic             capture;
  logic             sense_set;

  assign capture   = sel_index ? idx_rise_i : latch_req;
  assign sense_set = sel_index & idx_rise_i;

  always_comb begin
    sense_d = sense_q;
    if (sense_set)     sense_d = 1'b1;
    else if (sense_rd) sense_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (capture) hold_q <= count_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sense_q <= 1'b0;
    else        sense_q <= sense_d;
  end

  assign hold_o  = hold_q;
  assign sense_o = sense_q;

  // R5: strobe capture takes the count of that cycle
  p_strobe_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_index && latch_req) |=> (hold_q == $past(count_i)));
  // R6: with index selected, the strobe alone changes nothing
  p_strobe_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_index && !idx_rise_i) |=> $stable(hold_q));
  // R7: a read with no new index clears the flag
  p_sense_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_rd && !(sel_index && idx_rise_i)) |=> !sense_q);
  // R7: the flag rises only on a selected index event
  p_sense_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sense_q) |-> $past(sel_index && idx_rise_i));
endmodule

// File: rtl/qpa_axis.sv
module qpa_axis
  import qpa_pkg::*;
#(
  parameter int unsigned CNT_W       = CNT_W_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  input  logic             latch_req,
  input  logic             sel_index,
  input  logic             preset_en,
  input  logic             load_hold,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] preset_val,
  input  logic             sense_rd,
  output logic [CNT_W-1:0] hold_q,
  output logic             sense_q
);
  localparam int unsigned N_SYNC = 3;

  logic [N_SYNC-1:0] raw_in, sync_in;
  step_e             step;
  logic              idx_rise;
  logic [CNT_W-1:0]  count;

  assign raw_in = {enc_idx, enc_b, enc_a};

  qpa_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(sync_in)
  );

  qpa_decode u_decode (
    .clk(clk), .rst_n(rst_n),
    .a_s(sync_in[0]), .b_s(sync_in[1]), .idx_s(sync_in[2]),
    .step_o(step), .idx_rise_o(idx_rise)
  );

  qpa_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .step_i(step), .idx_rise_i(idx_rise),
    .preset_en(preset_en), .load_hold(load_hold),
    .load_val(load_val), .preset_val(preset_val), .count_o(count)
  );

  qpa_snap #(.CNT_W(CNT_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .count_i(count), .idx_rise_i(idx_rise),
    .latch_req(latch_req), .sel_index(sel_index), .sense_rd(sense_rd),
    .hold_o(hold_q), .sense_o(sense_q)
  );
endmodule

// File: tb/qpa_axis_tb.sv
module qpa_axis_tb;
  localparam int W = 24;
  localparam int NV = 13;
  // {A, B, expected count after moving to that code}
  localparam logic [W+1:0] VEC [NV] = '{
    {2'b01, 24'h000001}, {2'b11, 24'h000002}, {2'b10, 24'h000003},
    {2'b00, 24'h000004}, {2'b10, 24'h000003}, {2'b11, 24'h000002},
    {2'b01, 24'h000001}, {2'b00, 24'h000000}, {2'b10, 24'hFFFFFF},
    {2'b11, 24'hFFFFFE}, {2'b00, 24'hFFFFFE}, {2'b01, 24'hFFFFFF},
    {2'b00, 24'hFFFFFE}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic enc_a, enc_b, enc_idx, latch_req, sel_index, preset_en, load_hold, sense_rd;
  logic [W-1:0] load_val, preset_val, hold_q;
  logic sense_q;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  qpa_axis u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .latch_req(latch_req), .sel_index(sel_index), .preset_en(preset_en),
    .load_hold(load_hold), .load_val(load_val), .preset_val(preset_val),
    .sense_rd(sense_rd), .hold_q(hold_q), .sense_q(sense_q)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic snap();
    latch_req = 1'b1;
    @(negedge clk);
    latch_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enc_a = 0; enc_b = 0; enc_idx = 0; latch_req = 0;
    sel_index = 0; preset_en = 0; load_hold = 0; sense_rd = 0;
    load_val = '0; preset_val = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    check("R1 hold after reset", hold_q, 24'h0);
    check("R1 sense after reset", {23'h0, sense_q}, 24'h0);
    snap();
    check("R1 count after reset", hold_q, 24'h0);

    // R2 R3 R4: table walk, directions, bad step, wrap below zero
    for (int v = 0; v < NV; v++) begin
      {enc_a, enc_b} = VEC[v][W+1:W];
      wait_n(5);
      snap();
      check($sformatf("R2/R3/R4 vector %0d", v), hold_q, VEC[v][W-1:0]);
    end

    // R8: load held while a count edge arrives; load wins
    load_val = 24'h123456; load_hold = 1'b1;
    {enc_a, enc_b} = 2'b01;
    wait_n(6);
    load_hold = 1'b0;
    wait_n(2);
    snap();
    check("R8 load beats edge", hold_q, 24'h123456);

    // R6: index selected, strobe ignored
    sel_index = 1'b1;
    {enc_a, enc_b} = 2'b11;
    wait_n(5);
    snap();
    wait_n(1);
    check("R6 strobe ignored", hold_q, 24'h123456);
    check("R7 sense clear before index", {23'h0, sense_q}, 24'h0);
    enc_idx = 1'b1;
    wait_n(5);
    check("R6 index capture", hold_q, 24'h123457);
    check("R7 sense set", {23'h0, sense_q}, 24'h1);
    enc_idx = 1'b0;
    wait_n(4);
    check("R7 sense sticky", {23'h0, sense_q}, 24'h1);
    sense_rd = 1'b1;
    @(negedge clk);
    sense_rd = 1'b0;
    check("R7 sense cleared by read", {23'h0, sense_q}, 24'h0);

    // R9 R5 R7: preset on index with request source selected
    sel_index = 1'b0; preset_en = 1'b1; preset_val = 24'h800000;
    enc_idx = 1'b1;
    wait_n(5);
    enc_idx = 1'b0;
    wait_n(3);
    check("R7 no sense with strobe source", {23'h0, sense_q}, 24'h0);
    check("R5 index leaves hold alone", hold_q, 24'h123457);
    snap();
    check("R9 preset loaded", hold_q, 24'h800000);

    // R9: preset and a count edge in the same cycle
    enc_idx = 1'b1; {enc_a, enc_b} = 2'b10;
    wait_n(5);
    enc_idx = 1'b0; preset_en = 1'b0;
    wait_n(2);
    snap();
    check("R9 preset beats edge", hold_q, 24'h800000);

    // R4: wrap above the top
    load_val = 24'hFFFFFF; load_hold = 1'b1;
    wait_n(2);
    load_hold = 1'b0;
    {enc_a, enc_b} = 2'b00;
    wait_n(5);
    snap();
    check("R4 wrap up to zero", hold_q, 24'h000000);

    // R3: bad step from 00 to 11 keeps zero
    {enc_a, enc_b} = 2'b11;
    wait_n(5);
    snap();
    check("R3 double change ignored", hold_q, 24'h000000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule